// File: doc/BRIEF.md
# Command Byte Receive Buffer with Silence Watchdog

This block sits between a UART receiver and a multi-byte graphics command parser. Each byte that the receiver presents with a valid strobe is written into a first-in first-out store. The parser reads the oldest byte through a show-ahead pop interface. When the free space in the store falls under a programmable margin, a low-space flag is raised so that the sender can be asked to slow down. A byte that arrives while the store is full is discarded, and a sticky overflow flag records the loss until the next reset.

Because a lost byte breaks command framing, the block also measures how long the serial line has been silent. A prescaler divides the system clock into ticks. After a short silence, the block emits a single-cycle resync pulse that returns the parser to its start-of-command state. After a long silence, it raises an idle request that the display logic uses to enter a screensaver. Any received byte restarts the silence measurement and withdraws the idle request.

Top module: `cmd_rx_buffer`

## Requirements
- R1: After reset, count is 0, pop_valid, low_space, overflow, resync and idle_req are all 0.
- R2: Bytes leave the store in arrival order. pop_data shows the oldest stored byte whenever pop_valid is 1, and pop_valid equals (count != 0).
- R3: A byte with rx_valid=1 that arrives while count equals DEPTH is dropped, even if pop is high in the same cycle. overflow then becomes 1 and stays 1 until reset.
- R4: A pop while count is 0 has no effect on count or contents.
- R5: low_space is 1 exactly when the free space (DEPTH minus count) is less than LOW_FREE.
- R6: An accepted byte and a pop in the same cycle leave count unchanged. count never exceeds DEPTH.
- R7: resync is a one-cycle pulse. It is high in the cycle that follows the clock edge SHORT_TICKS*TICK_DIV cycles after the last edge with rx_valid=1, and it does not repeat while the line stays silent.
- R8: idle_req rises after the edge LONG_TICKS*TICK_DIV cycles after the last edge with rx_valid=1. It stays high until a byte arrives.
- R9: Any cycle with rx_valid=1 restarts both silence measurements, including the tick prescaler, and clears idle_req at that edge. This applies whether the byte is stored or dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present on rx_data this cycle |
| rx_data | input | 8 | Received byte |
| pop | input | 1 | Parser consumes the byte on pop_data |
| pop_valid | output | 1 | Store holds at least one byte |
| pop_data | output | 8 | Oldest stored byte |
| count | output | $clog2(DEPTH+1) | Number of stored bytes |
| low_space | output | 1 | Free space is below LOW_FREE |
| overflow | output | 1 | Sticky: a byte was dropped because the store was full |
| resync | output | 1 | One-cycle request to reset parser framing |
| idle_req | output | 1 | Screensaver request after long silence |

## Verification
The bench builds the block with DEPTH=16, LOW_FREE=5, TICK_DIV=4, SHORT_TICKS=5 and LONG_TICKS=12. With these values the store fills in sixteen bytes, so full, overflow and the low-space boundary at twelve stored bytes can be reached quickly. The values also bring the resync pulse down to cycle 20 and the idle request to cycle 48 of a silence. This makes it possible to check every cycle of both timeouts, including whether the pulse repeats and how a byte arriving mid-silence restarts the count.

// File: rtl/cmd_rx_buffer.sv
module cmd_rx_buffer #(
  parameter int DEPTH       = 256,
  parameter int LOW_FREE    = 50,
  parameter int TICK_DIV    = 250000,
  parameter int SHORT_TICKS = 5000,
  parameter int LONG_TICKS  = 60000,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(TICK_DIV + 1),
  localparam int IW = $clog2(LONG_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          pop,
  output logic          pop_valid,
  output logic [7:0]    pop_data,
  output logic [CW-1:0] count,
  output logic          low_space,
  output logic          overflow,
  output logic          resync,
  output logic          idle_req
);

  localparam logic [CW-1:0] FULL_MARK = CW'(DEPTH);
  localparam logic [CW-1:0] LOW_MARK  = CW'(DEPTH - LOW_FREE);
  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic [PW-1:0] pre;
  logic [IW-1:0] quiet;

  wire full    = fill == FULL_MARK;
  wire empty   = fill == '0;
  wire do_push = rx_valid && !full;
  wire do_pop  = pop && !empty;
  wire tick    = pre == PW'(TICK_DIV - 1);

  assign pop_valid = !empty;
  assign pop_data  = mem[rd_ptr];
  assign count     = fill;
  assign low_space = fill > LOW_MARK;

  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= rx_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST_SLOT) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST_SLOT) ? '0 : rd_ptr + 1'b1;
      fill <= fill + CW'(do_push) - CW'(do_pop);
      if (rx_valid && full) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre      <= '0;
      quiet    <= '0;
      resync   <= 1'b0;
      idle_req <= 1'b0;
    end else if (rx_valid) begin
      pre      <= '0;
      quiet    <= '0;
      resync   <= 1'b0;
      idle_req <= 1'b0;
    end else begin
      pre    <= tick ? '0 : pre + 1'b1;
      resync <= tick && (quiet == IW'(SHORT_TICKS - 1));
      if (tick && quiet != IW'(LONG_TICKS)) quiet <= quiet + 1'b1;
      if (tick && quiet == IW'(LONG_TICKS - 1)) idle_req <= 1'b1;
    end
  end

endmodule

module cmd_rx_buffer_props #(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          pop,
  input logic [CW-1:0] count,
  input logic          overflow,
  input logic          resync,
  input logic          idle_req
);

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && !pop) |=> count == CW'(DEPTH));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pop && !rx_valid) |=> count == '0);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  p_resync_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    resync |=> !resync);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && !rx_valid) |=> idle_req);

  p_byte_quiets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> (!idle_req && !resync));

endmodule

bind cmd_rx_buffer cmd_rx_buffer_props #(.DEPTH(DEPTH)) u_props (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .pop(pop),
  .count(count), .overflow(overflow), .resync(resync), .idle_req(idle_req)
);

// File: tb/cmd_rx_buffer_test.sv
`timescale 1ns/1ps
module cmd_rx_buffer_test;
  localparam int DEPTH = 16, LOW_FREE = 5, TDIV = 4, SHORT = 5, LONG = 12;
  localparam int SHORT_CYC = SHORT * TDIV, LONG_CYC = LONG * TDIV;

  logic clk = 0, rst_n = 0, rx_valid = 0, pop = 0;
  logic [7:0] rx_data = 0;
  logic pop_valid, low_space, overflow, resync, idle_req;
  logic [7:0] pop_data;
  logic [4:0] count;

  cmd_rx_buffer #(.DEPTH(DEPTH), .LOW_FREE(LOW_FREE), .TICK_DIV(TDIV),
                  .SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) uut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .pop(pop),
    .pop_valid(pop_valid), .pop_data(pop_data), .count(count), .low_space(low_space),
    .overflow(overflow), .resync(resync), .idle_req(idle_req));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] mq [DEPTH];
  int head = 0, tail = 0, mcount = 0;
  logic movf = 0;

  // {rx_valid, pop, count[4:0], low_space, overflow}
  localparam logic [8:0] VEC [0:23] = '{
    9'b10_00001_00, 9'b10_00010_00, 9'b10_00011_00, 9'b11_00011_00,
    9'b10_00100_00, 9'b10_00101_00, 9'b10_00110_00, 9'b10_00111_00,
    9'b10_01000_00, 9'b10_01001_00, 9'b10_01010_00, 9'b10_01011_00,
    9'b10_01100_10, 9'b10_01101_10, 9'b10_01110_10, 9'b10_01111_10,
    9'b10_10000_10, 9'b10_10000_11, 9'b11_01111_11, 9'b01_01110_11,
    9'b01_01101_11, 9'b01_01100_11, 9'b01_01011_01, 9'b00_01011_01
  };

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input logic rxv, input logic [7:0] d, input logic pv);
    bit do_push, do_pop;
    @(negedge clk);
    rx_valid = rxv; rx_data = d; pop = pv;
    #0;
    if (pv && mcount > 0) chk("R2 pop_data order", pop_data, mq[head]);
    do_push = rxv && mcount < DEPTH;
    do_pop  = pv && mcount > 0;
    if (rxv && mcount == DEPTH) movf = 1;
    @(posedge clk); #1;
    rx_valid = 0; pop = 0;
    if (do_push) begin mq[tail] = d; tail = (tail + 1) % DEPTH; end
    if (do_pop) head = (head + 1) % DEPTH;
    mcount = mcount + int'(do_push) - int'(do_pop);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; rx_valid = 0; pop = 0;
    @(negedge clk); rst_n = 1;
    head = 0; tail = 0; mcount = 0; movf = 0;
  endtask

  task automatic reset_checks();
    chk("R1 count", count, 0);
    chk("R1 pop_valid", pop_valid, 0);
    chk("R1 low_space", low_space, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 resync", resync, 0);
    chk("R1 idle_req", idle_req, 0);
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #5; rst_n = 1;
    @(posedge clk); #1;
    reset_checks();

    // table walk: R3 R5 R6 with model-checked data order (R2)
    for (int i = 0; i < 24; i++) begin
      logic [8:0] v;
      v = VEC[i];
      cyc(v[8], 8'(i * 7 + 3), v[7]);
      chk("R6 count", count, int'(v[6:2]));
      chk("R6 model count", count, mcount);
      chk("R5 low_space", low_space, int'(v[1]));
      chk("R3 overflow", overflow, int'(v[0]));
      chk("R2 pop_valid", pop_valid, int'(count != 0));
    end
    while (mcount > 0) cyc(0, 0, 1);
    chk("R2 drained", pop_valid, 0);
    chk("R3 overflow sticky", overflow, 1);

    do_reset();
    @(posedge clk); #1;
    reset_checks();

    // R4: pop on empty
    cyc(0, 0, 1);
    chk("R4 count after empty pop", count, 0);
    cyc(0, 0, 1);
    chk("R4 pop_valid after empty pop", pop_valid, 0);

    // R7 R8: silence after one byte
    cyc(1, 8'h55, 0);
    chk("R2 single byte", pop_data, 8'h55);
    for (int k = 1; k <= LONG_CYC + 8; k++) begin
      @(posedge clk); #1;
      chk($sformatf("R7 resync k=%0d", k), resync, int'(k == SHORT_CYC));
      chk($sformatf("R8 idle_req k=%0d", k), idle_req, int'(k >= LONG_CYC));
    end

    // R9: byte clears idle and restarts
    cyc(1, 8'h66, 0);
    chk("R9 idle cleared", idle_req, 0);
    for (int k = 1; k <= SHORT_CYC - 5; k++) begin
      @(posedge clk); #1;
      chk("R9 no early resync", resync, 0);
    end
    cyc(1, 8'h77, 0);
    for (int k = 1; k <= SHORT_CYC + 4; k++) begin
      @(posedge clk); #1;
      chk($sformatf("R9 restarted resync k=%0d", k), resync, int'(k == SHORT_CYC));
    end
    chk("R2 count three", count, 3);
    cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
    chk("R4 empty again", count, 0);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule